// File: doc/BRIEF.md
# Error-Diffusion Color Depth Reducer

This block sits at the end of a video pipeline and narrows each of the red, green and blue channels from `IN_W` bits to `OUT_W` bits. Plain truncation would leave visible bands in smooth gradients. To avoid that, the block carries each pixel's quantization remainder forward to its neighbours with two-row error diffusion. Half of the remainder goes to the next pixel on the same line. One quarter goes to the pixel directly below, and one quarter goes to the pixel below and one column to the left.

The stream arrives one RGB pixel per clock, qualified by `en`, together with the pixel's horizontal coordinate. Errors meant for the following line are kept in an on-chip buffer with one entry per column, addressed by that coordinate. The block has no vertical coordinate input. It starts a new line whenever the coordinate fails to rise. For that reason lines may be delivered top-down or bottom-up. While `en` is low, during blanking for example, the whole block holds still.

Top module: `errdiff_depth_reducer`

## Requirements
- R1: Every clock edge with `en` high accepts one pixel. The reduced pixel for that sample appears on the outputs after that same edge, and `out_valid` is high for exactly that cycle.
- R2: For each channel the corrected value is the input plus the incoming error, clamped to 2^IN_W-1. The output is the upper OUT_W bits of the clamped value, so an input at full scale always yields an output of all ones.
- R3: Let the remainder e be the low IN_W-OUT_W bits of the clamped value. The incoming error is the sum of three parts: floor(e/2) from the previous pixel of the same line, floor(e/4) stored for the same column, and floor(e/4) stored for the next column. The sum always stays below 2^(IN_W-OUT_W), so an input of zero yields an output of zero.
- R4: A sample starts a new line when it is the first after reset or when its coordinate is less than or equal to the previous sample's coordinate. The same-line error is then taken as zero. Within a line the coordinate rises by exactly one per sample.
- R5: Processing column x replaces the stored entry of column x with floor(e/4). The entries read for columns x and x+1 are those left by the previous line. When x is the last column (IMG_W-1), the next-column part is zero.
- R6: While `en` is low, the outputs, the same-line error and the column buffer keep their values, and `out_valid` is low.
- R7: Reset clears the outputs, `out_valid`, the same-line error and every column buffer entry to zero.
- R8: Over any line of mid-range inputs, the average of the outputs scaled by 2^(IN_W-OUT_W) stays within one output step of the average input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Sample qualifier; low freezes the block |
| x_pos | input | $clog2(IMG_W) | Column of the current sample |
| in_r | input | IN_W | Red input |
| in_g | input | IN_W | Green input |
| in_b | input | IN_W | Blue input |
| out_valid | output | 1 | Outputs hold a fresh reduced pixel |
| out_r | output | OUT_W | Reduced red |
| out_g | output | OUT_W | Reduced green |
| out_b | output | OUT_W | Reduced blue |

## Verification
Every sample is driven on a falling edge and captured on the next rising edge. Its reduced value and `out_valid` are due on that edge, so the bench compares them at the following falling edge against a bench model that is updated at drive time. Cycles with `en` low are checked at the same point against the values held before them. The diffused errors reach the outputs one pixel later on the same line and one line later in the buffer. Any error in them therefore shows up in later samples of the same stream. The per-line average is checked once, after the last sample of each gradient line.

// File: rtl/dith_pkg.sv
package dith_pkg;

    localparam int NCH = 3;

    typedef enum logic [1:0] {
        CH_RED   = 2'd0,
        CH_GREEN = 2'd1,
        CH_BLUE  = 2'd2
    } chan_e;

    // width of a stored quarter-remainder; never below one bit
    function automatic int quarter_w(input int shift);
        return (shift > 2) ? shift - 2 : 1;
    endfunction

endpackage

// File: rtl/dith_line_detect.sv
module dith_line_detect #(
    parameter int XW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [XW-1:0] x_pos,
    output logic          new_line
);
    logic          have_prev;
    logic [XW-1:0] x_prev;

    assign new_line = !have_prev || (x_pos <= x_prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            have_prev <= 1'b0;
            x_prev    <= '0;
        end else if (en) begin
            have_prev <= 1'b1;
            x_prev    <= x_pos;
        end
    end

    // within a line the coordinate steps by exactly one
    AST_X_STEP: assert property (@(posedge clk) disable iff (rst)
        (en && !new_line) |-> (x_pos == XW'(x_prev + 1'b1)));  // R4

endmodule

// File: rtl/dith_err_buf.sv
module dith_err_buf #(
    parameter int DEPTH = 640,
    parameter int DW    = 6,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_here,
    output logic [DW-1:0] rd_next
);
    logic [DW-1:0] mem [DEPTH];

    // reads see the contents before this edge's write: previous line
    assign rd_here = (int'(addr) < DEPTH) ? mem[addr] : '0;
    assign rd_next = (int'(addr) + 1 < DEPTH) ? mem[AW'(addr + 1'b1)] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && (int'(addr) < DEPTH)) begin
            mem[addr] <= wdata;
        end
    end

    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
        we |-> (int'(addr) < DEPTH));  // R5

endmodule

// File: rtl/dith_chan.sv
module dith_chan #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 4,
    parameter int SH    = IN_W - OUT_W,
    parameter int QW    = dith_pkg::quarter_w(IN_W - OUT_W)
) (
    input  logic [IN_W-1:0]  pix_in,
    input  logic [SH-1:0]    err_left,
    input  logic [QW-1:0]    err_up,
    input  logic [QW-1:0]    err_upright,
    output logic [OUT_W-1:0] pix_out,
    output logic [SH-1:0]    carry_out,
    output logic [QW-1:0]    quarter_out
);
    localparam int SW = IN_W + 2;
    localparam logic [SW-1:0] MAXV = SW'((1 << IN_W) - 1);

    logic [SW-1:0]   sum;
    logic [IN_W-1:0] sat;
    logic [SH-1:0]   rem;

    always_comb begin
        sum = SW'(pix_in) + SW'(err_left) + SW'(err_up) + SW'(err_upright);
        sat = (sum > MAXV) ? IN_W'(MAXV) : sum[IN_W-1:0];
    end

    assign pix_out   = sat[IN_W-1:SH];
    assign rem       = sat[SH-1:0];
    assign carry_out = rem >> 1;

    generate
        if (SH > 2) begin : g_quarter
            assign quarter_out = rem[SH-1:2];
        end else begin : g_no_quarter
            assign quarter_out = '0;
        end
    endgenerate

endmodule

// File: rtl/errdiff_depth_reducer.sv
module errdiff_depth_reducer #(
    parameter int IMG_W = 640,
    parameter int IN_W  = 8,
    parameter int OUT_W = 4,
    parameter int XW    = $clog2(IMG_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [XW-1:0]    x_pos,
    input  logic [IN_W-1:0]  in_r,
    input  logic [IN_W-1:0]  in_g,
    input  logic [IN_W-1:0]  in_b,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_r,
    output logic [OUT_W-1:0] out_g,
    output logic [OUT_W-1:0] out_b
);
    import dith_pkg::*;

    localparam int SH = IN_W - OUT_W;
    localparam int QW = quarter_w(SH);
    localparam int DW = NCH * QW;

    logic             new_line;
    logic [IN_W-1:0]  pin     [NCH];
    logic [OUT_W-1:0] q_now   [NCH];
    logic [OUT_W-1:0] pout    [NCH];
    logic [SH-1:0]    carry_q [NCH];
    logic [SH-1:0]    carry_n [NCH];
    logic [SH-1:0]    left    [NCH];
    logic [DW-1:0]    rd_here, rd_next, wr_quarters;

    assign pin[CH_RED]   = in_r;
    assign pin[CH_GREEN] = in_g;
    assign pin[CH_BLUE]  = in_b;

    dith_line_detect #(.XW(XW)) u_line (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .x_pos    (x_pos),
        .new_line (new_line)
    );

    dith_err_buf #(.DEPTH(IMG_W), .DW(DW), .AW(XW)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .we      (en),
        .addr    (x_pos),
        .wdata   (wr_quarters),
        .rd_here (rd_here),
        .rd_next (rd_next)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign left[c] = new_line ? '0 : carry_q[c];

            dith_chan #(.IN_W(IN_W), .OUT_W(OUT_W), .SH(SH), .QW(QW)) u_chan (
                .pix_in      (pin[c]),
                .err_left    (left[c]),
                .err_up      (rd_here[c*QW +: QW]),
                .err_upright (rd_next[c*QW +: QW]),
                .pix_out     (q_now[c]),
                .carry_out   (carry_n[c]),
                .quarter_out (wr_quarters[c*QW +: QW])
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    carry_q[c] <= '0;
                    pout[c]    <= '0;
                end else if (en) begin
                    carry_q[c] <= carry_n[c];
                    pout[c]    <= q_now[c];
                end
            end

            // full-scale input saturates to full-scale output
            AST_FULL_SCALE: assert property (@(posedge clk) disable iff (rst)
                (en && (pin[c] == {IN_W{1'b1}})) |=> (pout[c] == {OUT_W{1'b1}}));  // R2

            // diffused error alone never lifts a black input
            AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (rst)
                (en && (pin[c] == '0)) |=> (pout[c] == '0));  // R3
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= en;
    end

    assign out_r = pout[CH_RED];
    assign out_g = pout[CH_GREEN];
    assign out_b = pout[CH_BLUE];

    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(out_r) && $stable(out_g) && $stable(out_b)));  // R6

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !en |=> !out_valid);  // R6

endmodule

// File: tb/errdiff_depth_reducer_bench.sv
module errdiff_depth_reducer_bench;

    localparam int W     = 24;
    localparam int IN_W  = 8;
    localparam int OUT_W = 3;
    localparam int XW    = $clog2(W);
    localparam int SH    = IN_W - OUT_W;
    localparam int MAXV  = (1 << IN_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en = 1'b0;
    logic [XW-1:0]    x_pos = '0;
    logic [IN_W-1:0]  in_r = '0, in_g = '0, in_b = '0;
    logic             out_valid;
    logic [OUT_W-1:0] out_r, out_g, out_b;

    errdiff_depth_reducer #(.IMG_W(W), .IN_W(IN_W), .OUT_W(OUT_W)) u_errdiff_depth_reducer (
        .clk(clk), .rst(rst), .en(en), .x_pos(x_pos),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    always #5 clk = ~clk;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    // behavioural model state
    int  mbuf [W][3];
    int  mcarry [3];
    int  mpx;
    bit  mhave;
    int  exp_o [3];
    int  row_in_sum, row_out_sum, row_len;

    task automatic check(input string tag, input string what, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < W; i++) for (int c = 0; c < 3; c++) mbuf[i][c] = 0;
        for (int c = 0; c < 3; c++) begin mcarry[c] = 0; exp_o[c] = 0; end
        mhave = 1'b0;
        mpx   = 0;
    endfunction

    function automatic void model_step(input int x, input int r, input int g, input int b);
        int  pv [3];
        bit  nl;
        nl = !mhave || (x <= mpx);
        pv[0] = r; pv[1] = g; pv[2] = b;
        for (int c = 0; c < 3; c++) begin
            int s, e;
            s = pv[c] + (nl ? 0 : mcarry[c]) + mbuf[x][c] + ((x + 1 < W) ? mbuf[x+1][c] : 0);
            if (s > MAXV) s = MAXV;
            exp_o[c]   = s >> SH;
            e          = s & ((1 << SH) - 1);
            mcarry[c]  = e >> 1;
            mbuf[x][c] = e >> 2;
        end
        mhave = 1'b1;
        mpx   = x;
    endfunction

    // called at a falling edge; returns at the next falling edge after checking
    task automatic step(input bit e, input int x, input int r, input int g, input int b,
                        input string tag);
        int hold [3];
        hold[0] = out_r; hold[1] = out_g; hold[2] = out_b;
        en = e; x_pos = XW'(x);
        in_r = IN_W'(r); in_g = IN_W'(g); in_b = IN_W'(b);
        if (e) model_step(x, r, g, b);
        @(posedge clk);
        @(negedge clk);
        en = 1'b0;
        check("R1", "out_valid", out_valid, e);
        if (e) begin
            check(tag, "out_r", out_r, exp_o[0]);
            check(tag, "out_g", out_g, exp_o[1]);
            check(tag, "out_b", out_b, exp_o[2]);
            row_in_sum  += r + g + b;
            row_out_sum += (out_r + out_g + out_b) << SH;
            row_len     += 3;
        end else begin
            check("R6", "held out_r", out_r, hold[0]);
            check("R6", "held out_g", out_g, hold[1]);
            check("R6", "held out_b", out_b, hold[2]);
        end
    endtask

    // one line from x0 to x1; mode 0 gradient, 1 random; gaps inject idle cycles
    task automatic line(input int x0, input int x1, input int mode, input int seed_row,
                        input bit gaps, input string tag);
        row_in_sum = 0; row_out_sum = 0; row_len = 0;
        for (int x = x0; x <= x1; x++) begin
            int r, g, b;
            if (gaps && ($urandom % 4 == 0))
                step(1'b0, $urandom % W, $urandom % 256, $urandom % 256, $urandom % 256, "R6");
            if (mode == 0) begin
                r = (x * 7 + seed_row * 3) % 200 + 20;
                g = 100 + (x % 5) * 3;
                b = 37 + seed_row;
            end else begin
                r = $urandom % 256; g = $urandom % 256; b = $urandom % 256;
            end
            step(1'b1, x, r, g, b, tag);
        end
        if (mode == 0) begin
            int diff;
            diff = row_out_sum - row_in_sum;
            if (diff < 0) diff = -diff;
            // average within one output step: |sum diff| < count * 2^SH
            check("R8", "row average gap below one step", (diff < (row_len << SH)) ? 1 : 0, 1);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0ace));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // reset state
        check("R7", "out_valid after reset", out_valid, 0);
        check("R7", "out_r after reset", out_r, 0);
        check("R7", "out_g after reset", out_g, 0);
        check("R7", "out_b after reset", out_b, 0);

        // gradient frame, top-down, with idle gaps; last column exercises R5 edge
        for (int y = 0; y < 6; y++) line(0, W - 1, 0, y, 1'b1, "R3");
        // random content, column buffer carries across lines
        for (int y = 0; y < 4; y++) line(0, W - 1, 1, y, 1'b0, "R5");
        // bottom-up gradient order
        for (int y = 5; y >= 0; y--) line(0, W - 1, 0, y, 1'b1, "R4");

        // partial line starting mid-row, then one-sample lines at equal and lower x
        line(10, 15, 1, 0, 1'b0, "R4");
        step(1'b1, 5, 201, 77, 13, "R4");
        step(1'b1, 5, 201, 77, 13, "R4");
        step(1'b1, 3, 90, 91, 92, "R4");

        // full-scale and zero inputs
        for (int x = 0; x < W; x++) step(1'b1, x, MAXV, MAXV, 0, "R2");
        for (int x = 0; x < W; x++) begin
            step(1'b1, x, 0, $urandom % 256, MAXV, "R2");
            check("R3", "zero input stays zero", out_r, 0);
            check("R2", "full scale gives all ones", out_b, (1 << OUT_W) - 1);
        end

        // long idle stretch
        for (int i = 0; i < 8; i++) step(1'b0, i, 255, 255, 255, "R6");

        // reset mid-stream clears the column buffer and carry
        en = 1'b0; rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R7", "out_r after second reset", out_r, 0);
        check("R7", "out_valid after second reset", out_valid, 0);
        line(0, W - 1, 0, 2, 1'b0, "R7");
        line(0, W - 1, 1, 0, 1'b1, "R1");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule